// File: doc/BRIEF.md
# PC Card Address Window Decoder

This block sits between a system bus and one PC Card socket. It watches each bus cycle and decides whether that cycle belongs to the card. The decision uses seven programmable windows: five for memory and two for I/O. Each memory window has a start page, a stop page and an offset. Each I/O window has a start port and a stop port. Every window has its own enable bit in a shared control register.

A memory access that lands in an enabled memory window asserts the card enable. The card receives a translated address: the system page plus the window's offset. An I/O access that lands in an enabled I/O window also asserts the card enable, but the card receives the port address unchanged. When windows overlap, the lowest-numbered one wins. A separate active-low 16-bit memory-select output shows whether the current system address falls in any enabled memory window. It can be decoded either at fine 4 KB granularity or at coarse 128 KB granularity.

The cycle control is a three-state machine: IDLE, MEM_HIT and IO_HIT. On every clock edge it moves to MEM_HIT if the memory strobe is high and a memory window hits. Otherwise it moves to IO_HIT if the I/O strobe is high and an I/O window hits. In all other cases it moves to IDLE. Any state can move to any state on the next edge. The card enable is high in MEM_HIT and IO_HIT.

Top module: `pcw_decoder`

## Requirements
- R1: After reset every register is zero, so no window is enabled. After reset, card_en is 0, mem16_n is 1 and hit_win is 0.
- R2: The register map, selected by reg_addr, is as follows. Address 0 is the control register. Memory window w (0..4) uses address 1+3w for its start page, 2+3w for its stop page and 3+3w for its 14-bit offset. I/O window k (0..1) uses address 16+2k for its start port and 17+2k for its stop port. Control bits 4:0 enable memory windows 4..0 (bit w enables window w). Bit 5 is the fine-decode flag. Bits 7:6 enable I/O windows 1..0 (bit 6+k enables window k).
- R3: An access inside a window whose enable bit is 0 leaves card_en at 0.
- R4: A memory access hits window w when start_w <= sys_addr[23:12] <= stop_w, with both bounds inclusive. On a hit, card_en is 1 on the cycle after the strobe is sampled.
- R5: On a memory hit, card_addr[25:12] = (sys_addr[23:12] + offset_w) mod 2^14, and card_addr[11:0] = sys_addr[11:0].
- R6: An I/O access hits window k when start_k <= sys_addr[15:0] <= stop_k. Bits 23:16 are ignored. On a hit, card_addr is sys_addr[15:0] zero-extended to 26 bits.
- R7: If several enabled memory windows hit, the lowest-numbered window wins. hit_win gives its index, and hit_win is 0 whenever the state is not MEM_HIT.
- R8: With the fine-decode flag at 0, mem16_n is 0 when, for some enabled memory window, start[11:5] <= sys_addr[23:17] <= stop[11:5].
- R9: With the fine-decode flag at 1, mem16_n is 0 when sys_addr[23:12] lies in some enabled memory window, with both bounds inclusive.
- R10: mem16_n does not depend on either strobe. It reflects the address sampled one edge earlier.
- R11: When both strobes are high, a memory hit takes precedence. The I/O decode is used only if no memory window hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_addr | input | 24 | System address; I/O uses bits 15:0 |
| mem_strobe | input | 1 | Memory cycle qualifier |
| io_strobe | input | 1 | I/O cycle qualifier |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 5 | Register select |
| reg_wdata | input | 16 | Register write data |
| card_en | output | 1 | Card enable, high in MEM_HIT or IO_HIT |
| card_addr | output | 26 | Translated or passed-through card address |
| mem16_n | output | 1 | Active-low 16-bit memory select |
| hit_win | output | 3 | Index of the winning memory window |

## Verification
All four results (card_en, card_addr, hit_win and mem16_n) are registered once. Each is due exactly one clock edge after the inputs are sampled. A register write takes effect on the edge that captures it, so it changes the decode only from the following cycle onward. The bench drives every stimulus on a falling edge and compares on the next falling edge, using expected values computed from its own copy of the programmed registers. Register writes always occupy their own cycle, separate from accesses.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_IO   = 2'd2
    } pcw_state_e;
endpackage

// File: rtl/pcw_regs.sv
module pcw_regs #(
    parameter int N_MEM = 5,
    parameter int N_IO  = 2,
    parameter int PW    = 12,
    parameter int OW    = 14,
    parameter int IOW   = 16,
    parameter int WDW   = 16,
    parameter int RAW   = 5,
    parameter int CW    = N_MEM + 1 + N_IO
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [RAW-1:0]            waddr,
    input  logic [WDW-1:0]            wdata,
    output logic [CW-1:0]             ctrl,
    output logic [N_MEM-1:0][PW-1:0]  m_start,
    output logic [N_MEM-1:0][PW-1:0]  m_stop,
    output logic [N_MEM-1:0][OW-1:0]  m_off,
    output logic [N_IO-1:0][IOW-1:0]  i_start,
    output logic [N_IO-1:0][IOW-1:0]  i_stop
);
    localparam int IO_BASE = 1 + 3 * N_MEM;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (we && waddr == RAW'(0))
            ctrl <= wdata[CW-1:0];
    end

    for (genvar w = 0; w < N_MEM; w++) begin : g_mem
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                m_start[w] <= '0;
                m_stop[w]  <= '0;
                m_off[w]   <= '0;
            end else if (we) begin
                if (waddr == RAW'(1 + 3 * w)) m_start[w] <= wdata[PW-1:0];
                if (waddr == RAW'(2 + 3 * w)) m_stop[w]  <= wdata[PW-1:0];
                if (waddr == RAW'(3 + 3 * w)) m_off[w]   <= wdata[OW-1:0];
            end
        end
    end

    for (genvar k = 0; k < N_IO; k++) begin : g_io
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                i_start[k] <= '0;
                i_stop[k]  <= '0;
            end else if (we) begin
                if (waddr == RAW'(IO_BASE + 2 * k))     i_start[k] <= wdata[IOW-1:0];
                if (waddr == RAW'(IO_BASE + 2 * k + 1)) i_stop[k]  <= wdata[IOW-1:0];
            end
        end
    end
endmodule

// File: rtl/pcw_mem_win.sv
module pcw_mem_win #(
    parameter int PW  = 12,
    parameter int CSH = 5
) (
    input  logic          en,
    input  logic          fine,
    input  logic [PW-1:0] page,
    input  logic [PW-1:0] start,
    input  logic [PW-1:0] stop,
    output logic          hit,
    output logic          sel16
);
    logic fine_in, coarse_in;

    always_comb begin
        fine_in   = (page >= start) && (page <= stop);
        coarse_in = (page[PW-1:CSH] >= start[PW-1:CSH]) &&
                    (page[PW-1:CSH] <= stop[PW-1:CSH]);
        hit       = en && fine_in;
        sel16     = en && (fine ? fine_in : coarse_in);
    end
endmodule

// File: rtl/pcw_prio.sv
module pcw_prio #(
    parameter int N  = 5,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/pcw_decoder.sv
module pcw_decoder
    import pcw_pkg::*;
#(
    parameter int N_MEM = 5,
    parameter int N_IO  = 2,
    parameter int SAW   = 24,
    parameter int PLSB  = 12,
    parameter int CAW   = 26,
    parameter int IOW   = 16,
    parameter int CLSB  = 17,
    parameter int WDW   = 16,
    localparam int RAW  = $clog2(1 + 3 * N_MEM + 2 * N_IO),
    localparam int IW   = (N_MEM > 1) ? $clog2(N_MEM) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SAW-1:0]  sys_addr,
    input  logic            mem_strobe,
    input  logic            io_strobe,
    input  logic            reg_we,
    input  logic [RAW-1:0]  reg_addr,
    input  logic [WDW-1:0]  reg_wdata,
    output logic            card_en,
    output logic [CAW-1:0]  card_addr,
    output logic            mem16_n,
    output logic [IW-1:0]   hit_win
);
    localparam int PW  = SAW - PLSB;
    localparam int OW  = CAW - PLSB;
    localparam int CSH = CLSB - PLSB;
    localparam int CW  = N_MEM + 1 + N_IO;
    localparam int FINE_BIT = N_MEM;
    localparam int IO_EN_LSB = N_MEM + 1;

    logic [CW-1:0]            ctrl;
    logic [N_MEM-1:0][PW-1:0] m_start, m_stop;
    logic [N_MEM-1:0][OW-1:0] m_off;
    logic [N_IO-1:0][IOW-1:0] i_start, i_stop;

    pcw_regs #(
        .N_MEM(N_MEM), .N_IO(N_IO), .PW(PW), .OW(OW),
        .IOW(IOW), .WDW(WDW), .RAW(RAW), .CW(CW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_addr),
        .wdata(reg_wdata), .ctrl(ctrl), .m_start(m_start),
        .m_stop(m_stop), .m_off(m_off), .i_start(i_start), .i_stop(i_stop)
    );

    logic [PW-1:0]    page;
    logic [N_MEM-1:0] m_hit, m_sel16;
    logic [N_IO-1:0]  i_hit;

    assign page = sys_addr[SAW-1:PLSB];

    for (genvar w = 0; w < N_MEM; w++) begin : g_win
        pcw_mem_win #(.PW(PW), .CSH(CSH)) u_win (
            .en(ctrl[w]), .fine(ctrl[FINE_BIT]), .page(page),
            .start(m_start[w]), .stop(m_stop[w]),
            .hit(m_hit[w]), .sel16(m_sel16[w])
        );
    end

    for (genvar k = 0; k < N_IO; k++) begin : g_iow
        assign i_hit[k] = ctrl[IO_EN_LSB + k] &&
                          (sys_addr[IOW-1:0] >= i_start[k]) &&
                          (sys_addr[IOW-1:0] <= i_stop[k]);
    end

    logic          m_any;
    logic [IW-1:0] m_idx;

    pcw_prio #(.N(N_MEM), .IW(IW)) u_prio (
        .req(m_hit), .any(m_any), .idx(m_idx)
    );

    logic [OW-1:0] xlat_page;
    assign xlat_page = OW'(page) + m_off[m_idx];

    pcw_state_e state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        if (mem_strobe && m_any)
            state_d = ST_MEM;
        else if (io_strobe && (|i_hit))
            state_d = ST_IO;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            card_addr <= '0;
            hit_win   <= '0;
            mem16_n   <= 1'b1;
        end else begin
            mem16_n <= ~(|m_sel16);
            unique case (state_d)
                ST_MEM: begin
                    card_addr <= {xlat_page, sys_addr[PLSB-1:0]};
                    hit_win   <= m_idx;
                end
                ST_IO: begin
                    card_addr <= CAW'(sys_addr[IOW-1:0]);
                    hit_win   <= '0;
                end
                default: begin
                    card_addr <= card_addr;
                    hit_win   <= '0;
                end
            endcase
        end
    end

    assign card_en = (state_q != ST_IDLE);

    assert_mem_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEM) |-> $past(mem_strobe));
    assert_low_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEM) |-> card_addr[PLSB-1:0] == $past(sys_addr[PLSB-1:0]));
    assert_io_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IO) |-> card_addr == CAW'($past(sys_addr[IOW-1:0])));
    assert_io_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IO) |-> $past(io_strobe));
    assert_no_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl[N_MEM-1:0]) == '0) |-> (mem16_n && state_q != ST_MEM));
    assert_idle_win_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_MEM) |-> hit_win == '0);
endmodule

// File: tb/sim_pcw_decoder.sv
module sim_pcw_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] sys_addr = '0;
    logic        mem_strobe = 1'b0, io_strobe = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        card_en, mem16_n;
    logic [25:0] card_addr;
    logic [2:0]  hit_win;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    logic [11:0] sh_ms [5];
    logic [11:0] sh_me [5];
    logic [13:0] sh_mo [5];
    logic [15:0] sh_is [2];
    logic [15:0] sh_ie [2];
    logic [7:0]  sh_ctrl;

    always #2 clk = ~clk;

    pcw_decoder u0 (
        .clk(clk), .rst_n(rst_n), .sys_addr(sys_addr), .mem_strobe(mem_strobe),
        .io_strobe(io_strobe), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .card_en(card_en), .card_addr(card_addr),
        .mem16_n(mem16_n), .hit_win(hit_win)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit mhit(input int w, input logic [23:0] a);
        return sh_ctrl[w] && a[23:12] >= sh_ms[w] && a[23:12] <= sh_me[w];
    endfunction

    function automatic bit ihit(input int k, input logic [23:0] a);
        return sh_ctrl[6+k] && a[15:0] >= sh_is[k] && a[15:0] <= sh_ie[k];
    endfunction

    function automatic bit sel16(input logic [23:0] a);
        bit r = 0;
        for (int w = 0; w < 5; w++) begin
            if (sh_ctrl[w]) begin
                if (sh_ctrl[5]) r |= mhit(w, a);
                else r |= (a[23:17] >= sh_ms[w][11:5]) && (a[23:17] <= sh_me[w][11:5]);
            end
        end
        return r;
    endfunction

    task automatic wr(input logic [4:0] ad, input logic [15:0] d);
        @(negedge clk);
        mem_strobe = 0; io_strobe = 0;
        reg_we = 1; reg_addr = ad; reg_wdata = d;
        if (ad == 0) sh_ctrl = d[7:0];
        else if (ad <= 15) begin
            int w = (ad - 1) / 3;
            case ((ad - 1) % 3)
                0: sh_ms[w] = d[11:0];
                1: sh_me[w] = d[11:0];
                default: sh_mo[w] = d[13:0];
            endcase
        end else begin
            int k = (ad - 16) / 2;
            if (ad[0] == 0) sh_is[k] = d; else sh_ie[k] = d;
        end
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic acc(input string tag, input logic [23:0] a, input bit m, input bit i);
        int wi = -1;
        bit ie = 0;
        logic [25:0] ea;
        for (int w = 4; w >= 0; w--) if (mhit(w, a)) wi = w;
        for (int k = 0; k < 2; k++) if (ihit(k, a)) ie = 1;
        sys_addr = a; mem_strobe = m; io_strobe = i;
        @(negedge clk);
        chk({tag, " mem16_n"}, 32'(mem16_n), 32'(!sel16(a)));
        if (m && wi >= 0) begin
            ea = {14'(a[23:12] + sh_mo[wi]), a[11:0]};
            chk({tag, " card_en"}, 32'(card_en), 1);
            chk({tag, " card_addr"}, 32'(card_addr), 32'(ea));
            chk({tag, " hit_win"}, 32'(hit_win), 32'(wi));
        end else if (i && ie) begin
            chk({tag, " card_en"}, 32'(card_en), 1);
            chk({tag, " card_addr"}, 32'(card_addr), 32'(a[15:0]));
            chk({tag, " hit_win"}, 32'(hit_win), 0);
        end else begin
            chk({tag, " card_en"}, 32'(card_en), 0);
            chk({tag, " hit_win"}, 32'(hit_win), 0);
        end
    endtask

    initial begin
        for (int w = 0; w < 5; w++) begin sh_ms[w] = 0; sh_me[w] = 0; sh_mo[w] = 0; end
        for (int k = 0; k < 2; k++) begin sh_is[k] = 0; sh_ie[k] = 0; end
        sh_ctrl = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 card_en", 32'(card_en), 0);
        chk("R1 mem16_n", 32'(mem16_n), 1);
        chk("R1 hit_win", 32'(hit_win), 0);
        acc("R1 zero regs", 24'h000000, 1, 1);

        // R2 map: window 0 regs at 1,2,3
        wr(5'd1, 16'h0C0); wr(5'd2, 16'h0C3); wr(5'd3, 16'h3F50);
        acc("R3 mem disabled", 24'h0C1234, 1, 0);
        wr(5'd0, 16'h0021);
        acc("R5 wrap", 24'h0C1234, 1, 0);
        acc("R4 low bound", 24'h0C0000, 1, 0);
        acc("R4 high bound", 24'h0C3FFF, 1, 0);
        acc("R4 below", 24'h0BFFFF, 1, 0);
        acc("R4 above", 24'h0C4000, 1, 0);
        acc("R10 no strobe", 24'h0C1000, 0, 0);
        // R7 overlap, window 2 regs at 7,8,9
        wr(5'd7, 16'h0C2); wr(5'd8, 16'h0D0); wr(5'd9, 16'h0005);
        wr(5'd0, 16'h0005);
        acc("R7 low wins", 24'h0C2000, 1, 0);
        acc("R7 only w2", 24'h0C5ABC, 1, 0);
        acc("R8 coarse", 24'h0DF000, 1, 0);
        wr(5'd0, 16'h0025);
        acc("R9 fine", 24'h0DF000, 1, 0);
        acc("R9 fine in", 24'h0D0FFF, 0, 1);
        // R6 I/O window 0 at 16,17
        wr(5'd16, 16'h0300); wr(5'd17, 16'h031F);
        acc("R3 io disabled", 24'h000305, 0, 1);
        wr(5'd0, 16'h0045);
        acc("R6 io top", 24'h00031F, 0, 1);
        acc("R6 io past", 24'h000320, 0, 1);
        acc("R6 high ignored", 24'hAB0305, 0, 1);
        wr(5'd19, 16'h0400); wr(5'd18, 16'h0400);
        acc("R3 io1 disabled", 24'h000400, 0, 1);
        wr(5'd0, 16'h00C5);
        acc("R2 io1 bit7", 24'h000400, 0, 1);
        acc("R11 both mem", 24'h0C0300, 1, 1);
        acc("R11 both io", 24'h000305, 1, 1);

        void'($urandom(32'd7311));
        for (int it = 0; it < 300; it++) begin
            for (int w = 0; w < 5; w++) begin
                logic [11:0] s = 12'($urandom);
                wr(5'(1 + 3*w), 16'(s));
                wr(5'(2 + 3*w), 16'(s + 12'($urandom_range(0, 40))));
                wr(5'(3 + 3*w), 16'($urandom));
            end
            for (int k = 0; k < 2; k++) begin
                logic [15:0] s = 16'($urandom);
                wr(5'(16 + 2*k), s);
                wr(5'(17 + 2*k), s + 16'($urandom_range(0, 300)));
            end
            wr(5'd0, 16'($urandom));
            for (int j = 0; j < 8; j++) begin
                logic [23:0] a = 24'($urandom);
                if ($urandom_range(0, 1) == 1)
                    a[23:12] = sh_ms[$urandom_range(0, 4)] + 12'($urandom_range(0, 20));
                else if ($urandom_range(0, 1) == 1)
                    a[15:0] = sh_is[$urandom_range(0, 1)] + 16'($urandom_range(0, 200));
                acc("R4 rnd", a, 1'($urandom), 1'($urandom));
            end
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule